// File: doc/BRIEF.md
# TMDS Character Boundary Synchronizer

This block takes a raw 10-bit parallel word every clock from a deserializer whose word boundary is arbitrary. It forms a 20-bit window from the word arriving now and the word before it, and searches every one of the ten bit offsets in that window for one of the four control characters that a video link sends during blanking. Because blanking repeats the same control character many times at a fixed offset, a long run of identical matches at one offset is strong evidence of the true character boundary. Pixel data rarely imitates the heavily toggling control characters for long.

Once such a run is complete, the block adopts that offset. From then on it emits aligned 10-bit characters with one register of latency. The search never stops: any later blanking interval that shows a complete run at a different offset moves the alignment, and a one-cycle pulse marks each adoption. Data decoding, disparity handling and clock generation are left to neighbouring blocks.

Top module: `chbound_sync`

## Requirements
- R1: While reset is asserted, and before any alignment has been adopted, `locked` and `relock_pulse` are 0 and `align_shift` is 0. While reset is asserted, `char_out` is also 0.
- R2: The window at offset k (0 to 9) is bits k to k+9 of the 20-bit value {word_in, previous word_in}, where the previous word sits in bits 0 to 9. Bit 0 of a word is the earliest bit on the line. `align_shift` reports the adopted offset.
- R3: Only these four characters, written bit 9 first, count as markers: 1101010100, 0010101011, 0101010100, 1010101011. A stream of any other characters never causes lock.
- R4: An offset is adopted when the same marker has been found at the same offset in RUN_LEN (default 8) consecutive words. RUN_LEN-1 consecutive matches are not enough.
- R5: The run restarts when a word carries a different marker, when the marker moves to a different offset, or when a word has no marker at any offset. When several offsets match in one word, the lowest offset is taken.
- R6: After each clock edge, `char_out` holds the window of that edge's word pair at the offset in effect after the edge. The valid flag for `char_out` is `locked`.
- R7: `relock_pulse` is high for exactly one cycle on the first adoption and on every change of the adopted offset. A run that completes at the offset already adopted gives no pulse.
- R8: Once set, `locked` stays high until reset. `align_shift` changes only through a completed run, so data words and runs that are too short leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_in | input | 10 | Raw deserialized word, one per clock |
| char_out | output | 10 | Aligned character |
| locked | output | 1 | An offset has been adopted; qualifies `char_out` |
| align_shift | output | 4 | Adopted bit offset, 0 to 9 |
| relock_pulse | output | 1 | One-cycle strobe on each adoption |

## Verification
The assertions assume that `word_in` is a contiguous bit stream presenting a new word on every clock. They also assume that the lowest-offset priority makes each word resolve to at most one marker. Under these assumptions, an adoption always places a marker on `char_out`, and the offset only moves on a pulse. The stimulus builds the words by slicing a character sequence at a chosen bit offset, so that boundaries are known exactly. In steady runs it uses markers whose rotations are not themselves markers, so only the true offset can match. The single deliberate slip in the stream is placed so that neither offset collects a full run.

// File: rtl/chbound_pkg.sv
package chbound_pkg;
  localparam int CHAR_W    = 10;
  localparam int NUM_SHIFT = CHAR_W;
  localparam int SHIFT_W   = $clog2(NUM_SHIFT);
  localparam int PAIR_W    = 2 * CHAR_W;

  typedef logic [CHAR_W-1:0]  char_t;
  typedef logic [SHIFT_W-1:0] shift_t;

  typedef enum logic [1:0] {
    CTL_SYM0 = 2'd0,
    CTL_SYM1 = 2'd1,
    CTL_SYM2 = 2'd2,
    CTL_SYM3 = 2'd3
  } ctl_code_e;

  typedef struct packed {
    logic      hit;
    ctl_code_e code;
  } ctl_match_t;

  localparam char_t CTL_PAT0 = 10'b1101010100;
  localparam char_t CTL_PAT1 = 10'b0010101011;
  localparam char_t CTL_PAT2 = 10'b0101010100;
  localparam char_t CTL_PAT3 = 10'b1010101011;

  // Maps a 10-bit window to a marker identity, or no hit.
  function automatic ctl_match_t ctl_classify(input char_t w);
    ctl_match_t m;
    m.hit  = 1'b1;
    m.code = CTL_SYM0;
    case (w)
      CTL_PAT0: m.code = CTL_SYM0;
      CTL_PAT1: m.code = CTL_SYM1;
      CTL_PAT2: m.code = CTL_SYM2;
      CTL_PAT3: m.code = CTL_SYM3;
      default:  m.hit  = 1'b0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/chbound_scan.sv
module chbound_scan
  import chbound_pkg::*;
(
  input  char_t     cur_word,
  input  char_t     prev_word,
  output logic      hit,
  output shift_t    hit_shift,
  output ctl_code_e hit_code
);
  logic [PAIR_W-1:0] pair;
  ctl_match_t        match [NUM_SHIFT];

  assign pair = {cur_word, prev_word};

  for (genvar k = 0; k < NUM_SHIFT; k++) begin : g_pos
    assign match[k] = ctl_classify(pair[k +: CHAR_W]);
  end

  // Scan downward so that the lowest matching offset wins (R5).
  always_comb begin
    hit       = 1'b0;
    hit_shift = '0;
    hit_code  = CTL_SYM0;
    for (int k = NUM_SHIFT - 1; k >= 0; k--) begin
      if (match[k].hit) begin
        hit       = 1'b1;
        hit_shift = shift_t'(k);
        hit_code  = match[k].code;
      end
    end
  end
endmodule

// File: rtl/chbound_runtrk.sv
module chbound_runtrk
  import chbound_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  shift_t    hit_shift,
  input  ctl_code_e hit_code,
  output logic      locked,
  output shift_t    cur_shift,
  output shift_t    next_shift,
  output logic      relock
);
  localparam int             CNT_W   = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_hit_q;
  ctl_code_e        last_code_q;
  shift_t           last_shift_q;
  shift_t           shift_q, shift_d;
  logic             locked_q, locked_d;
  logic             pulse_q;
  logic             same_run, adopt, tag_en;

  always_comb begin
    same_run = hit && last_hit_q && (hit_code == last_code_q) &&
               (hit_shift == last_shift_q);
    if (!hit)                 cnt_d = '0;
    else if (!same_run)       cnt_d = CNT_W'(1);
    else if (cnt_q == CNT_TOP) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
    adopt    = (cnt_d == CNT_TOP) && (!locked_q || (hit_shift != shift_q));
    shift_d  = adopt ? hit_shift : shift_q;
    locked_d = locked_q | adopt;
    tag_en   = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      last_hit_q   <= 1'b0;
      last_code_q  <= CTL_SYM0;
      last_shift_q <= '0;
      shift_q      <= '0;
      locked_q     <= 1'b0;
      pulse_q      <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      last_hit_q <= hit;
      if (tag_en) begin
        last_code_q  <= hit_code;
        last_shift_q <= hit_shift;
      end
      shift_q  <= shift_d;
      locked_q <= locked_d;
      pulse_q  <= adopt;
    end
  end

  assign locked     = locked_q;
  assign cur_shift  = shift_q;
  assign next_shift = shift_d;
  assign relock     = pulse_q;

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP); // R4
  AST_PULSE_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (cnt_q == CNT_TOP)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q); // R8
  AST_SHIFT_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_q |-> $stable(shift_q)); // R8
  AST_FIRST_LOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> pulse_q); // R7
endmodule

// File: rtl/chbound_align.sv
module chbound_align
  import chbound_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  char_t  cur_word,
  input  char_t  prev_word,
  input  shift_t sel,
  output char_t  char_out
);
  localparam shift_t SEL_MAX = shift_t'(NUM_SHIFT - 1);

  logic [PAIR_W-1:0] pair;
  char_t             win [NUM_SHIFT];
  char_t             char_d, char_q;

  assign pair = {cur_word, prev_word};

  for (genvar k = 0; k < NUM_SHIFT; k++) begin : g_win
    assign win[k] = pair[k +: CHAR_W];
  end

  always_comb begin
    char_d = (sel <= SEL_MAX) ? win[sel] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) char_q <= '0;
    else        char_q <= char_d;
  end

  assign char_out = char_q;
endmodule

// File: rtl/chbound_sync.sv
module chbound_sync
  import chbound_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] word_in,
  output logic [CHAR_W-1:0] char_out,
  output logic              locked,
  output logic [SHIFT_W-1:0] align_shift,
  output logic              relock_pulse
);
  logic [1:0] rst_pipe_q;
  logic       srst_n;
  char_t      prev_q, prev_d;
  logic       scan_hit;
  shift_t     scan_shift;
  ctl_code_e  scan_code;
  shift_t     shift_now, shift_next;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  always_comb prev_d = word_in;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  chbound_scan u_scan (
    .cur_word  (word_in),
    .prev_word (prev_q),
    .hit       (scan_hit),
    .hit_shift (scan_shift),
    .hit_code  (scan_code)
  );

  chbound_runtrk #(.RUN_LEN(RUN_LEN)) u_runtrk (
    .clk        (clk),
    .rst_n      (srst_n),
    .hit        (scan_hit),
    .hit_shift  (scan_shift),
    .hit_code   (scan_code),
    .locked     (locked),
    .cur_shift  (shift_now),
    .next_shift (shift_next),
    .relock     (relock_pulse)
  );

  chbound_align u_align (
    .clk       (clk),
    .rst_n     (srst_n),
    .cur_word  (word_in),
    .prev_word (prev_q),
    .sel       (shift_next),
    .char_out  (char_out)
  );

  assign align_shift = shift_now;

  AST_ADOPT_SHOWS_MARKER: assert property (@(posedge clk) disable iff (!srst_n)
    relock_pulse |-> ctl_classify(char_out).hit); // R6
  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!srst_n)
    align_shift < SHIFT_W'(NUM_SHIFT)); // R2
endmodule

// File: tb/chbound_sync_tb.sv
`timescale 1ns/1ps
module chbound_sync_tb;
  localparam logic [9:0] CA = 10'b1101010100;
  localparam logic [9:0] CB = 10'b0101010100;
  localparam logic [9:0] DZ = 10'b0000000000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] word_in;
  logic [9:0] char_out;
  logic       locked;
  logic [3:0] align_shift;
  logic       relock_pulse;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [9:0] chs [64];
  int         nch;
  logic       obs_lock  [64];
  logic       obs_pulse [64];
  logic [3:0] obs_shift [64];
  logic [9:0] obs_char  [64];

  always #2.5 clk = ~clk;

  chbound_sync u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_in      (word_in),
    .char_out     (char_out),
    .locked       (locked),
    .align_shift  (align_shift),
    .relock_pulse (relock_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic sbit(input int b);
    if (b < 0 || b >= nch * 10) return 1'b0;
    return chs[b / 10][b % 10];
  endfunction

  task automatic fill(input int from, input int cnt, input logic [9:0] v);
    for (int i = 0; i < cnt; i++) chs[from + i] = v;
  endtask

  task automatic clear_chars(input int n);
    nch = n;
    for (int i = 0; i < 64; i++) chs[i] = DZ;
  endtask

  // Words sliced from the character stream at offset d0, switching to d1 from word slip on.
  task automatic run(input int d0, input int d1, input int slip, input int nw);
    for (int t = 0; t < nw; t++) begin
      logic [9:0] w;
      int d;
      d = (t < slip) ? d0 : d1;
      for (int i = 0; i < 10; i++) w[i] = sbit(10 * t + d + i);
      word_in = w;
      @(posedge clk);
      @(negedge clk);
      obs_lock[t]  = locked;
      obs_pulse[t] = relock_pulse;
      obs_shift[t] = align_shift;
      obs_char[t]  = char_out;
    end
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    word_in = DZ;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    word_in = 10'h3FF;
    repeat (2) @(negedge clk);
    check("R1 locked in reset", locked, 0);
    check("R1 pulse in reset", relock_pulse, 0);
    check("R1 shift in reset", align_shift, 0);
    check("R1 char in reset", char_out, 0);
    do_reset();
    check("R1 locked after release", locked, 0);
    check("R1 shift after release", align_shift, 0);
  endtask

  task automatic t_each_marker();
    logic [9:0] codes [4];
    codes[0] = CA; codes[1] = 10'b0010101011; codes[2] = CB; codes[3] = 10'b1010101011;
    for (int c = 0; c < 4; c++) begin
      do_reset();
      clear_chars(12);
      fill(1, 8, codes[c]);
      run(0, 0, 0, 11);
      check("R4 seventh match no lock", obs_lock[8], 0);
      check("R4 eighth match locks", obs_lock[9], 1);
      check("R3 marker accepted", obs_lock[10], 1);
      check("R7 pulse on first adopt", obs_pulse[9], 1);
      check("R7 pulse one cycle", obs_pulse[10], 0);
      check("R2 offset zero", obs_shift[9], 0);
      check("R6 char at adopt", obs_char[9], codes[c]);
      check("R6 next char", obs_char[10], DZ);
    end
  endtask

  task automatic t_short_run();
    int seen;
    do_reset();
    clear_chars(12);
    fill(1, 7, CA);
    run(0, 0, 0, 11);
    seen = 0;
    for (int t = 0; t < 11; t++) seen += obs_lock[t];
    check("R4 seven matches only", seen, 0);
  endtask

  task automatic t_non_marker();
    int seen;
    do_reset();
    clear_chars(20);
    fill(0, 20, 10'b1010101010);
    run(0, 0, 0, 19);
    seen = 0;
    for (int t = 0; t < 19; t++) seen += obs_lock[t];
    check("R3 non-marker stream", seen, 0);
  endtask

  task automatic t_breaks();
    int seen;
    // Marker changes mid-run.
    do_reset();
    clear_chars(13);
    fill(1, 4, CA);
    fill(5, 5, CB);
    run(0, 0, 0, 12);
    seen = 0;
    for (int t = 0; t < 12; t++) seen += obs_lock[t];
    check("R5 marker change restarts", seen, 0);
    // Gap of one data word.
    do_reset();
    clear_chars(14);
    fill(1, 5, CA);
    fill(7, 5, CA);
    run(0, 0, 0, 13);
    seen = 0;
    for (int t = 0; t < 13; t++) seen += obs_lock[t];
    check("R5 missing marker restarts", seen, 0);
    // Bit slip moves the offset mid-run.
    do_reset();
    clear_chars(16);
    fill(1, 12, CA);
    run(0, 3, 5, 15);
    seen = 0;
    for (int t = 0; t < 15; t++) seen += obs_lock[t];
    check("R5 offset change restarts", seen, 0);
  endtask

  task automatic t_unaligned();
    logic [9:0] data [5];
    data[0] = 10'h3FF; data[1] = 10'h0F0; data[2] = 10'h1C3; data[3] = 10'h2A5; data[4] = 10'h07E;
    do_reset();
    clear_chars(17);
    fill(1, 10, CA);
    for (int i = 0; i < 5; i++) chs[11 + i] = data[i];
    run(3, 3, 0, 16);
    check("R4 unaligned not yet", obs_lock[7], 0);
    check("R4 unaligned lock", obs_lock[8], 1);
    check("R7 unaligned pulse", obs_pulse[8], 1);
    check("R2 offset seven", obs_shift[8], 7);
    for (int t = 8; t < 16; t++) check("R6 aligned char", obs_char[t], chs[t]);
    check("R8 data keeps offset", obs_shift[15], 7);
  endtask

  task automatic t_relock();
    int pulses;
    int lows;
    clear_chars(26);
    fill(3, 7, CA);
    fill(11, 12, CA);
    run(6, 6, 0, 25);
    pulses = 0;
    lows = 0;
    for (int t = 0; t < 25; t++) begin
      pulses += obs_pulse[t];
      lows   += (obs_lock[t] == 1'b0);
    end
    check("R8 lock never drops", lows, 0);
    check("R8 short run ignored", obs_shift[17], 7);
    check("R7 relock pulse", obs_pulse[18], 1);
    check("R2 new offset", obs_shift[18], 4);
    check("R7 single pulse", pulses, 1);
    check("R7 no pulse at same offset", obs_pulse[22], 0);
    check("R6 char after relock", obs_char[20], CA);
  endtask

  initial begin
    t_reset();
    t_each_marker();
    t_short_run();
    t_non_marker();
    t_breaks();
    t_unaligned();
    t_relock();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule